// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit settles, for a small processor core, whether a conditional relative branch or a skip instruction is taken. It also produces the program counter that follows the instruction and the number of cycles the instruction costs. The decoder presents the current status register, the kind of instruction, a condition index with a polarity bit, a signed relative offset, the current program counter, and a flag saying whether the instruction after this one is two words long. For skips it also presents a tested bit value and an operand-equality result. Fetch, decode and the reads of registers or I/O bits stay outside the unit.

A request is accepted on any cycle where `req_valid` is high. Its result is registered and appears on the outputs one clock later, with `res_valid` high. The unit handles one request every cycle with no stalls.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset, `res_valid`, `taken`, `next_pc` and `cycles` are all zero.
- R2: `res_valid` is high exactly in the cycle after a cycle where `req_valid` is high. The result belongs to that request.
- R3: With `kind` = 0 (status-bit branch), `cond_sel` picks one status bit, using the order 7=I, 6=T, 5=H, 4=S, 3=V, 2=N, 1=Z, 0=C. The branch is taken when that bit equals `cond_pol`.
- R4: With `kind` = 1 (signed compare branch), the test value is N XOR V. For `cond_pol` = 0 (greater-or-equal) the branch is taken when the test value is 0. For `cond_pol` = 1 (less-than) it is taken when the test value is 1.
- R5: Unsigned same-or-higher is `kind` 0, `cond_sel` 0, `cond_pol` 0, and is taken when C = 0. Unsigned lower is the same with `cond_pol` 1, and is taken when C = 1.
- R6: A taken branch gives `next_pc` = pc + sign-extended offset + 1, modulo 2^PC_W, with `cycles` = 2.
- R7: Any request that is not taken gives `taken` = 0, `next_pc` = pc + 1 (modulo 2^PC_W) and `cycles` = 1.
- R8: With `kind` = 2 (bit skip), the skip is taken when `test_bit` equals `cond_pol`.
- R9: With `kind` = 3 (equality skip), the skip is taken when `operands_equal` is 1. `cond_pol` has no effect.
- R10: A taken skip advances `next_pc` by 3 and reports 3 cycles when `next_two_word` is 1. Otherwise it advances by 2 and reports 2 cycles.
- R11: `next_two_word` has no effect on branches or on skips that are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| kind | input | 2 | 0 bit branch, 1 signed branch, 2 bit skip, 3 equality skip |
| cond_sel | input | 3 | Status bit index for kind 0 |
| cond_pol | input | 1 | Condition polarity |
| status | input | 8 | Status register {I,T,H,S,V,N,Z,C} |
| offset | input | OFS_W | Two's-complement branch offset |
| pc | input | PC_W | Current program counter |
| next_two_word | input | 1 | Following instruction is two words long |
| test_bit | input | 1 | Tested bit value for kind 2 |
| operands_equal | input | 1 | Operand equality for kind 3 |
| res_valid | output | 1 | Result valid |
| next_pc | output | PC_W | Following program counter |
| taken | output | 1 | Branch taken or skip performed |
| cycles | output | 2 | Cycle cost of the instruction |

## Verification
The bench builds the unit with PC_W = 8 and OFS_W = 7. With an 8-bit counter, wrap-around at both ends is easy to reach: a branch backward from address 0, a skip forward from 0xFE, and a not-taken step from 0xFF. The 7-bit offset covers both extremes, -64 and +63. Every status bit is tried under both polarities, and the two-word flag is exercised on skips, taken and not taken, and on branches.

// File: rtl/branch_skip_unit.sv
module branch_skip_unit #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       kind,
  input  logic [2:0]       cond_sel,
  input  logic             cond_pol,
  input  logic [7:0]       status,
  input  logic [OFS_W-1:0] offset,
  input  logic [PC_W-1:0]  pc,
  input  logic             next_two_word,
  input  logic             test_bit,
  input  logic             operands_equal,
  output logic             res_valid,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic [1:0]       cycles
);
  localparam int EXT_W = PC_W - OFS_W;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

  logic [PC_W-1:0] ofs_ext;
  logic            is_skip;
  logic            hit;
  logic [PC_W-1:0] step;
  logic [1:0]      cost;

  assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
  assign is_skip = kind[1];

  always_comb begin
    case (kind)
      2'd0:    hit = (status[cond_sel] == cond_pol);
      2'd1:    hit = ((status[FLAG_N] ^ status[FLAG_V]) == cond_pol);
      2'd2:    hit = (test_bit == cond_pol);
      default: hit = operands_equal;
    endcase
  end

  always_comb begin
    if (!hit) begin
      step = PC_W'(1);
      cost = 2'd1;
    end else if (!is_skip) begin
      step = ofs_ext + PC_W'(1);
      cost = 2'd2;
    end else if (next_two_word) begin
      step = PC_W'(3);
      cost = 2'd3;
    end else begin
      step = PC_W'(2);
      cost = 2'd2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= 2'd0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        next_pc <= pc + step;
        taken   <= hit;
        cycles  <= cost;
      end
    end
  end
endmodule

module branch_skip_unit_chk #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       kind,
  input logic [PC_W-1:0]  pc,
  input logic             next_two_word,
  input logic             res_valid,
  input logic [PC_W-1:0]  next_pc,
  input logic             taken,
  input logic [1:0]       cycles
);
  // R2
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  // R2
  no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  // R7
  not_taken_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken) |-> (cycles == 2'd1 && next_pc == $past(pc) + PC_W'(1)));

  // R6
  branch_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken && !$past(kind[1])) |-> cycles == 2'd2);

  // R10
  skip_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && taken && $past(kind[1])) |->
      (next_pc == $past(pc) + PC_W'(cycles) && cycles == ($past(next_two_word) ? 2'd3 : 2'd2)));
endmodule

bind branch_skip_unit branch_skip_unit_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .pc(pc),
  .next_two_word(next_two_word), .res_valid(res_valid), .next_pc(next_pc),
  .taken(taken), .cycles(cycles)
);

// File: tb/sim_branch_skip_unit.sv
module sim_branch_skip_unit;
  localparam int PC_W  = 8;
  localparam int OFS_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] kind = '0;
  logic [2:0] cond_sel = '0;
  logic cond_pol = 1'b0;
  logic [7:0] status = '0;
  logic [OFS_W-1:0] offset = '0;
  logic [PC_W-1:0] pc = '0;
  logic next_two_word = 1'b0;
  logic test_bit = 1'b0;
  logic operands_equal = 1'b0;
  logic res_valid;
  logic [PC_W-1:0] next_pc;
  logic taken;
  logic [1:0] cycles;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [PC_W-1:0] q_pc[$];
  logic            q_tk[$];
  logic [1:0]      q_cy[$];
  string           q_tag[$];

  always #10 clk = ~clk;

  branch_skip_unit #(.PC_W(PC_W), .OFS_W(OFS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind),
    .cond_sel(cond_sel), .cond_pol(cond_pol), .status(status), .offset(offset),
    .pc(pc), .next_two_word(next_two_word), .test_bit(test_bit),
    .operands_equal(operands_equal), .res_valid(res_valid), .next_pc(next_pc),
    .taken(taken), .cycles(cycles)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic [1:0] k, input logic [2:0] sel,
                       input logic pol, input logic [7:0] st, input int ofs,
                       input int p, input logic two, input logic tb, input logic eq);
    logic hit;
    logic [PC_W-1:0] ep;
    logic [1:0] ec;
    case (k)
      2'd0: hit = (st[sel] == pol);
      2'd1: hit = pol ? (st[2] != st[3]) : (st[2] == st[3]);
      2'd2: hit = (tb == pol);
      default: hit = eq;
    endcase
    if (!hit) begin ep = PC_W'(p + 1); ec = 2'd1; end
    else if (k < 2) begin ep = PC_W'(p + ofs + 1); ec = 2'd2; end
    else if (two) begin ep = PC_W'(p + 3); ec = 2'd3; end
    else begin ep = PC_W'(p + 2); ec = 2'd2; end
    @(negedge clk);
    req_valid = 1'b1; kind = k; cond_sel = sel; cond_pol = pol; status = st;
    offset = OFS_W'(ofs); pc = PC_W'(p); next_two_word = two;
    test_bit = tb; operands_equal = eq;
    q_pc.push_back(ep); q_tk.push_back(hit); q_cy.push_back(ec); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_pc.size() == 0) check("R2 unexpected result", 1, 0);
      else begin
        string t;
        t = q_tag.pop_front();
        check({t, " next_pc"}, next_pc, q_pc.pop_front());
        check({t, " taken"}, taken, q_tk.pop_front());
        check({t, " cycles"}, cycles, q_cy.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 res_valid", res_valid, 0);
    check("R1 taken", taken, 0);
    check("R1 next_pc", next_pc, 0);
    check("R1 cycles", cycles, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 idle res_valid", res_valid, 0);

    for (int b = 0; b < 8; b++) begin
      drive("R3 bit set pol1", 2'd0, 3'(b), 1'b1, 8'(1 << b), 5, 16, 1'b0, 1'b0, 1'b0);
      drive("R3 bit set pol0", 2'd0, 3'(b), 1'b0, 8'(1 << b), 5, 16, 1'b0, 1'b0, 1'b0);
      drive("R3 bit clr pol0", 2'd0, 3'(b), 1'b0, 8'(~(1 << b)), -3, 40, 1'b1, 1'b0, 1'b0);
      drive("R3 bit clr pol1", 2'd0, 3'(b), 1'b1, 8'(~(1 << b)), -3, 40, 1'b0, 1'b0, 1'b0);
    end
    drive("R4 ge N0V0", 2'd1, 3'd0, 1'b0, 8'h00, 10, 100, 1'b0, 1'b0, 1'b0);
    drive("R4 ge N1V1", 2'd1, 3'd0, 1'b0, 8'h0C, 10, 100, 1'b0, 1'b0, 1'b0);
    drive("R4 ge N1V0", 2'd1, 3'd0, 1'b0, 8'h04, 10, 100, 1'b0, 1'b0, 1'b0);
    drive("R4 lt N0V1", 2'd1, 3'd0, 1'b1, 8'h08, 10, 100, 1'b0, 1'b0, 1'b0);
    drive("R4 lt N1V1", 2'd1, 3'd0, 1'b1, 8'hFF, 10, 100, 1'b0, 1'b0, 1'b0);
    drive("R5 same-or-higher C0", 2'd0, 3'd0, 1'b0, 8'hFE, 7, 50, 1'b0, 1'b0, 1'b0);
    drive("R5 same-or-higher C1", 2'd0, 3'd0, 1'b0, 8'h01, 7, 50, 1'b0, 1'b0, 1'b0);
    drive("R5 lower C1", 2'd0, 3'd0, 1'b1, 8'h01, 7, 50, 1'b0, 1'b0, 1'b0);
    drive("R6 max forward", 2'd0, 3'd1, 1'b1, 8'h02, 63, 20, 1'b0, 1'b0, 1'b0);
    drive("R6 max backward", 2'd0, 3'd1, 1'b1, 8'h02, -64, 100, 1'b0, 1'b0, 1'b0);
    drive("R6 wrap below zero", 2'd0, 3'd1, 1'b1, 8'h02, -5, 0, 1'b0, 1'b0, 1'b0);
    drive("R6 wrap above top", 2'd0, 3'd1, 1'b1, 8'h02, 40, 250, 1'b0, 1'b0, 1'b0);
    drive("R7 not taken wrap", 2'd0, 3'd1, 1'b0, 8'h02, 40, 255, 1'b0, 1'b0, 1'b0);
    drive("R8 skip bit1 pol1", 2'd2, 3'd0, 1'b1, 8'h00, 0, 30, 1'b0, 1'b1, 1'b0);
    drive("R8 skip bit0 pol0", 2'd2, 3'd0, 1'b0, 8'h00, 0, 30, 1'b0, 1'b0, 1'b0);
    drive("R8 no skip bit0 pol1", 2'd2, 3'd0, 1'b1, 8'h00, 0, 30, 1'b1, 1'b0, 1'b0);
    drive("R9 eq pol0", 2'd3, 3'd0, 1'b0, 8'h00, 0, 60, 1'b0, 1'b0, 1'b1);
    drive("R9 eq pol1", 2'd3, 3'd0, 1'b1, 8'h00, 0, 60, 1'b0, 1'b0, 1'b1);
    drive("R9 neq pol1", 2'd3, 3'd0, 1'b1, 8'h00, 0, 60, 1'b0, 1'b0, 1'b0);
    drive("R10 two-word skip", 2'd3, 3'd0, 1'b0, 8'h00, 0, 70, 1'b1, 1'b0, 1'b1);
    drive("R10 skip wrap", 2'd2, 3'd0, 1'b1, 8'h00, 0, 254, 1'b1, 1'b1, 1'b0);
    drive("R11 branch two-word", 2'd1, 3'd0, 1'b0, 8'h00, -2, 80, 1'b1, 1'b0, 1'b0);
    drive("R11 no-skip two-word", 2'd3, 3'd0, 1'b0, 8'h00, 0, 80, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 drained", q_pc.size(), 0);
    check("R2 idle after burst", res_valid, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule